// File: doc/BRIEF.md
# Three-Mode Interrupt Acceptance Unit

This unit sits next to a small 8-bit processor core and decides, at each instruction boundary, whether an interrupt is taken and where control goes. It watches a level-sensitive maskable request and an edge-sensitive non-maskable request. It obeys disable, enable and set-mode commands from the core. When it accepts a request, it reports the kind of entry and the entry address. In one mode it instead reports that the byte on the data bus is to be executed as an opcode.

While interrupts are held, a maskable request is not taken. It is remembered as pending. A non-maskable request is taken even while interrupts are held, and it always wins over a pending maskable request. An enable command does not act at once. The hold is dropped at the first instruction boundary after the enable, so the instruction that follows the enable can finish before a new request is taken. Taking any interrupt sets the hold again.

Top module: `irq_accept`

## Requirements
- R1: After reset the mode is 0, the hold is clear, `pend_o` reads 0, and `ack_o` and `exec_o` are low.
- R2: A set-mode strobe loads `mode_i` when it is 0, 1 or 2. A strobe carrying the value 3 leaves the mode unchanged.
- R3: `pend_o` encodes the pending state as 2'd0 for none, 2'd1 for a maskable request, and 2'd3 whenever a non-maskable request is pending, whether or not a maskable one is also pending.
- R4: A disable strobe sets the hold. While the hold is set, a maskable request produces no acknowledge and leaves `pend_o` at 2'd1.
- R5: After an enable strobe, the hold clears at the next cycle with `boundary_i` high. No maskable request is taken at that boundary. A pending one is taken at the boundary after it. With nothing pending, the enable only clears the hold.
- R6: A rising edge on `nmi_i` is recorded and taken at the next boundary, even while the hold is set. It gives `kind_o` 2'd3 and target 0x0066. Holding `nmi_i` high does not cause a second acceptance.
- R7: When a non-maskable and a maskable request are both pending at a boundary, the non-maskable one is taken first. The maskable one stays pending.
- R8: In mode 1, a maskable acceptance gives `kind_o` 2'd1 and target 0x0038.
- R9: In mode 2, a maskable acceptance gives `kind_o` 2'd2. The target has `vbase_i` in bits 15:8 and `bus_i` in bits 7:0, with bit 0 forced to 0.
- R10: In mode 0, a maskable acceptance gives `kind_o` 2'd0 with `exec_o` high and `op_o` equal to `bus_i`. `exec_o` is low for every other kind.
- R11: Every acceptance sets the hold and clears the pending flag of the request that was served.
- R12: An acceptance is decided on the clock edge where `boundary_i` is high. `ack_o`, `kind_o`, `target_o`, `exec_o` and `op_o` are registered and hold that result for exactly the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_i | input | 1 | Maskable request, level |
| nmi_i | input | 1 | Non-maskable request, rising edge |
| dis_i | input | 1 | Disable strobe: sets the hold |
| en_i | input | 1 | Enable strobe: clears the hold at the next boundary |
| setmode_i | input | 1 | Set-mode strobe |
| mode_i | input | 2 | Mode value loaded by `setmode_i` |
| vbase_i | input | 8 | Vector base, upper byte of the mode-2 target |
| bus_i | input | 8 | Data bus byte during acknowledge |
| boundary_i | input | 1 | Instruction boundary from the core |
| ack_o | output | 1 | One-cycle acceptance pulse |
| kind_o | output | 2 | 0 opcode, 1 fixed restart, 2 vectored, 3 non-maskable |
| target_o | output | 16 | Entry address |
| exec_o | output | 1 | Execute `op_o` in place of a fetch |
| op_o | output | 8 | Captured bus byte |
| pend_o | output | 2 | Pending-state code |

## Verification
The bench sends a maskable request while interrupts are held and checks that no acknowledge appears at any boundary until an enable has been followed by two boundaries. A design that applies the enable at once would produce an acknowledge one boundary early. It raises a non-maskable edge while a maskable request is pending, with the hold both set and clear. A wrong priority shows up as a vectored acknowledge arriving before the non-maskable one, or as a lost pending code. It feeds odd bus bytes in vectored mode and writes the illegal mode value 3: a design that drops bit 0 wrongly gives an odd target, and one that accepts the illegal mode changes the kind reported.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;
   typedef enum logic [1:0] {
      K_OPC = 2'd0,
      K_RST = 2'd1,
      K_VEC = 2'd2,
      K_NMI = 2'd3
   } kind_e;

   localparam logic [1:0] PEND_NONE = 2'd0;
   localparam logic [1:0] PEND_MASK = 2'd1;
   localparam logic [1:0] PEND_NMI  = 2'd3;
   localparam logic [1:0] MODE_BAD  = 2'd3;
endpackage

// File: rtl/irq_accept_pend.sv
module irq_accept_pend (
   input  logic clk,
   input  logic rst_n,
   input  logic irq_i,
   input  logic nmi_i,
   input  logic take_irq_i,
   input  logic take_nmi_i,
   output logic pm_o,
   output logic pn_o
);
   logic nmi_q;
   logic pm_q, pn_q;
   logic nmi_rise;

   assign nmi_rise = nmi_i & ~nmi_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         nmi_q <= 1'b0;
         pm_q  <= 1'b0;
         pn_q  <= 1'b0;
      end else begin
         nmi_q <= nmi_i;
         if (take_irq_i) pm_q <= 1'b0;
         else            pm_q <= pm_q | irq_i;
         if (nmi_rise)        pn_q <= 1'b1;
         else if (take_nmi_i) pn_q <= 1'b0;
      end
   end

   assign pm_o = pm_q;
   assign pn_o = pn_q;

   // R6: a recorded non-maskable request always follows a high input
   a_r6_nmi_from_input: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pn_o) |-> $past(nmi_i));
   // R11: a served maskable request does not stay pending
   a_r11_mask_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      take_irq_i |=> !pm_o);
endmodule

// File: rtl/irq_accept_hold.sv
module irq_accept_hold (
   input  logic clk,
   input  logic rst_n,
   input  logic dis_i,
   input  logic en_i,
   input  logic boundary_i,
   input  logic take_i,
   output logic hold_o
);
   logic hold_q, arm_q;
   logic hold_d, arm_d;

   always_comb begin
      hold_d = hold_q;
      arm_d  = arm_q;
      if (en_i) arm_d = 1'b1;
      if (boundary_i && arm_q) begin
         hold_d = 1'b0;
         arm_d  = 1'b0;
      end
      if (take_i || dis_i) begin
         hold_d = 1'b1;
         arm_d  = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_q <= 1'b0;
         arm_q  <= 1'b0;
      end else begin
         hold_q <= hold_d;
         arm_q  <= arm_d;
      end
   end

   assign hold_o = hold_q;

   // R5: the hold only drops at an instruction boundary
   a_r5_release_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hold_o) |-> $past(boundary_i));
   // R4: a disable always leaves the hold set
   a_r4_disable_holds: assert property (@(posedge clk) disable iff (!rst_n)
      dis_i |=> hold_o);
endmodule

// File: rtl/irq_accept_target.sv
module irq_accept_target
   import irq_accept_pkg::*;
#(
   parameter int                DATA_W    = 8,
   parameter int                ADDR_W    = 16,
   parameter logic [ADDR_W-1:0] RST_ADDR  = 'h0038,
   parameter logic [ADDR_W-1:0] NMI_ADDR  = 'h0066,
   parameter bit                VEC_ALIGN = 1'b1
) (
   input  logic [1:0]        mode_i,
   input  logic              nmi_i,
   input  logic [DATA_W-1:0] vbase_i,
   input  logic [DATA_W-1:0] bus_i,
   output kind_e             kind_o,
   output logic [ADDR_W-1:0] target_o,
   output logic              exec_o
);
   localparam int VEC_W = 2 * DATA_W;

   logic [DATA_W-1:0] low;

   generate
      if (VEC_ALIGN) begin : g_align
         localparam logic [DATA_W-1:0] LOW_MASK = ~DATA_W'(1);
         assign low = bus_i & LOW_MASK;
      end else begin : g_raw
         assign low = bus_i;
      end
   endgenerate

   always_comb begin
      target_o = '0;
      exec_o   = 1'b0;
      if (nmi_i) begin
         kind_o   = K_NMI;
         target_o = NMI_ADDR;
      end else begin
         case (mode_i)
            2'd0: begin
               kind_o = K_OPC;
               exec_o = 1'b1;
            end
            2'd1: begin
               kind_o   = K_RST;
               target_o = RST_ADDR;
            end
            default: begin
               kind_o = K_VEC;
               target_o[VEC_W-1:0] = {vbase_i, low};
            end
         endcase
      end
   end
endmodule

// File: rtl/irq_accept.sv
module irq_accept
   import irq_accept_pkg::*;
#(
   parameter int                DATA_W    = 8,
   parameter int                ADDR_W    = 16,
   parameter logic [ADDR_W-1:0] RST_ADDR  = 'h0038,
   parameter logic [ADDR_W-1:0] NMI_ADDR  = 'h0066,
   parameter bit                VEC_ALIGN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              irq_i,
   input  logic              nmi_i,
   input  logic              dis_i,
   input  logic              en_i,
   input  logic              setmode_i,
   input  logic [1:0]        mode_i,
   input  logic [DATA_W-1:0] vbase_i,
   input  logic [DATA_W-1:0] bus_i,
   input  logic              boundary_i,
   output logic              ack_o,
   output logic [1:0]        kind_o,
   output logic [ADDR_W-1:0] target_o,
   output logic              exec_o,
   output logic [DATA_W-1:0] op_o,
   output logic [1:0]        pend_o
);
   generate
      if (ADDR_W < 2 * DATA_W) begin : g_bad_width
         $error("irq_accept: ADDR_W must hold base and bus byte");
      end
      if (DATA_W < 2) begin : g_bad_data
         $error("irq_accept: DATA_W too small");
      end
   endgenerate

   logic [1:0]        mode_q;
   logic              pm, pn, hold;
   logic              take_irq, take_nmi, take;
   kind_e             kind_d;
   logic [ADDR_W-1:0] target_d;
   logic              exec_d;

   logic              ack_q, exec_q;
   kind_e             kind_q;
   logic [ADDR_W-1:0] target_q;
   logic [DATA_W-1:0] op_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                             mode_q <= 2'd0;
      else if (setmode_i && mode_i != MODE_BAD) mode_q <= mode_i;
   end

   assign take_nmi = boundary_i & pn;
   assign take_irq = boundary_i & ~pn & pm & ~hold;
   assign take     = take_nmi | take_irq;

   irq_accept_pend u_pend (
      .clk        (clk),
      .rst_n      (rst_n),
      .irq_i      (irq_i),
      .nmi_i      (nmi_i),
      .take_irq_i (take_irq),
      .take_nmi_i (take_nmi),
      .pm_o       (pm),
      .pn_o       (pn)
   );

   irq_accept_hold u_hold (
      .clk        (clk),
      .rst_n      (rst_n),
      .dis_i      (dis_i),
      .en_i       (en_i),
      .boundary_i (boundary_i),
      .take_i     (take),
      .hold_o     (hold)
   );

   irq_accept_target #(
      .DATA_W    (DATA_W),
      .ADDR_W    (ADDR_W),
      .RST_ADDR  (RST_ADDR),
      .NMI_ADDR  (NMI_ADDR),
      .VEC_ALIGN (VEC_ALIGN)
   ) u_target (
      .mode_i   (mode_q),
      .nmi_i    (pn),
      .vbase_i  (vbase_i),
      .bus_i    (bus_i),
      .kind_o   (kind_d),
      .target_o (target_d),
      .exec_o   (exec_d)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ack_q    <= 1'b0;
         exec_q   <= 1'b0;
         kind_q   <= K_OPC;
         target_q <= '0;
         op_q     <= '0;
      end else begin
         ack_q  <= take;
         exec_q <= take & exec_d;
         if (take) begin
            kind_q   <= kind_d;
            target_q <= target_d;
            op_q     <= bus_i;
         end
      end
   end

   assign ack_o    = ack_q;
   assign kind_o   = kind_q;
   assign target_o = target_q;
   assign exec_o   = exec_q;
   assign op_o     = op_q;
   assign pend_o   = pn ? PEND_NMI : (pm ? PEND_MASK : PEND_NONE);

   // R2: the illegal mode value never reaches the mode register
   a_r2_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
      mode_q != MODE_BAD);
   // R4: a maskable acceptance only follows a cycle without hold
   a_r4_no_take_held: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_o && kind_o != K_NMI) |-> !$past(hold));
   // R7: a maskable acceptance never overtakes a pending non-maskable one
   a_r7_nmi_first: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_o && kind_o != K_NMI) |-> !$past(pn));
   // R8: fixed restart target
   a_r8_rst_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_o && kind_o == K_RST) |-> target_o == RST_ADDR);
   // R10: opcode execution flag only with a mode-0 acknowledge
   a_r10_exec_only_opc: assert property (@(posedge clk) disable iff (!rst_n)
      exec_o |-> (ack_o && kind_o == K_OPC));
   // R11: every acceptance leaves interrupts held
   a_r11_hold_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
      ack_o |-> hold);

   generate
      if (VEC_ALIGN) begin : g_chk_align
         // R9: vectored targets are even
         a_r9_vec_even: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_o && kind_o == K_VEC) |-> !target_o[0]);
      end
   endgenerate
endmodule

// File: tb/irq_accept_tb_top.sv
module irq_accept_tb_top;
   localparam int CLK_P = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic irq = 1'b0, nmi = 1'b0, dis = 1'b0, en = 1'b0, setm = 1'b0, bnd = 1'b0;
   logic [1:0]  mode = 2'd0;
   logic [7:0]  vbase = 8'h00, bus = 8'h00;
   logic        ack_o, exec_o;
   logic [1:0]  kind_o, pend_o;
   logic [15:0] target_o;
   logic [7:0]  op_o;

   int n_chk = 0;
   int n_bad = 0;
   logic [26:0] exp_q[$];

   always #(CLK_P/2) clk = ~clk;

   irq_accept dut_i (
      .clk (clk), .rst_n (rst_n), .irq_i (irq), .nmi_i (nmi),
      .dis_i (dis), .en_i (en), .setmode_i (setm), .mode_i (mode),
      .vbase_i (vbase), .bus_i (bus), .boundary_i (bnd),
      .ack_o (ack_o), .kind_o (kind_o), .target_o (target_o),
      .exec_o (exec_o), .op_o (op_o), .pend_o (pend_o)
   );

   task automatic report(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // one cycle of stimulus, applied at the falling edge
   task automatic cyc(input bit i_irq, input bit i_dis, input bit i_en,
                      input bit i_bnd, input bit i_setm, input logic [1:0] i_mode);
      @(negedge clk);
      irq = i_irq; dis = i_dis; en = i_en; bnd = i_bnd; setm = i_setm; mode = i_mode;
   endtask

   task automatic idle();
      cyc(0, 0, 0, 0, 0, 2'd0);
   endtask

   task automatic expect_ack(input logic [1:0] k, input logic [15:0] t,
                             input bit x, input logic [7:0] op);
      exp_q.push_back({k, t, x, op});
   endtask

   task automatic chk_pend(input logic [1:0] e, input string req);
      report(pend_o == e, req, 32'(pend_o), 32'(e));
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n && ack_o) begin
         if (exp_q.size() == 0) begin
            report(1'b0, "R5 unexpected acknowledge", {14'd0, kind_o, target_o}, 32'd0);
         end else begin
            logic [26:0] e;
            string tag;
            e = exp_q.pop_front();
            case (e[26:25])
               2'd0: tag = "R10";
               2'd1: tag = "R8";
               2'd2: tag = "R9";
               default: tag = "R6";
            endcase
            report({kind_o, target_o, exec_o} == e[26:8], tag,
                   {13'd0, kind_o, target_o, exec_o}, {13'd0, e[26:8]});
            if (e[8]) report(op_o == e[7:0], "R10 op", 32'(op_o), 32'(e[7:0]));
         end
      end
   end

   initial begin
      #(CLK_P * 200000);
      report(1'b0, "watchdog", 32'd0, 32'd1);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle();
      // R1: reset state
      chk_pend(2'd0, "R1 pend");
      report(ack_o == 1'b0 && exec_o == 1'b0, "R1 ack/exec", {ack_o, exec_o}, 0);

      // R1/R10: default mode 0 executes the bus byte
      bus = 8'hAB;
      cyc(1, 0, 0, 0, 0, 2'd0);
      idle();
      chk_pend(2'd1, "R3 maskable");
      expect_ack(2'd0, 16'h0000, 1'b1, 8'hAB);
      cyc(0, 0, 0, 1, 0, 2'd0);
      idle();
      chk_pend(2'd0, "R11 cleared");

      // R4: held after acceptance, request only pends
      cyc(0, 0, 0, 0, 1, 2'd1);
      cyc(1, 0, 0, 0, 0, 2'd0);
      idle();
      chk_pend(2'd1, "R4 pending");
      cyc(0, 0, 0, 1, 0, 2'd0);
      cyc(0, 0, 0, 1, 0, 2'd0);
      idle();
      chk_pend(2'd1, "R4 still pending");

      // R5: enable acts after one boundary; R8 restart target
      cyc(0, 0, 1, 0, 0, 2'd0);
      cyc(0, 0, 0, 1, 0, 2'd0);
      idle();
      expect_ack(2'd1, 16'h0038, 1'b0, 8'h00);
      cyc(0, 0, 0, 1, 0, 2'd0);
      idle();
      chk_pend(2'd0, "R11 after restart");

      // R6/R7: non-maskable while held and with maskable pending
      cyc(0, 0, 0, 0, 1, 2'd2);
      vbase = 8'h12; bus = 8'h35;
      cyc(1, 0, 0, 0, 0, 2'd0);
      nmi = 1'b1;
      idle();
      idle();
      chk_pend(2'd3, "R3 nmi code");
      expect_ack(2'd3, 16'h0066, 1'b0, 8'h00);
      cyc(0, 0, 0, 1, 0, 2'd0);
      idle();
      chk_pend(2'd1, "R7 maskable kept");
      cyc(0, 0, 0, 1, 0, 2'd0);   // level nmi, held: nothing
      cyc(0, 0, 1, 0, 0, 2'd0);
      cyc(0, 0, 0, 1, 0, 2'd0);
      expect_ack(2'd2, 16'h1234, 1'b0, 8'h00);
      cyc(0, 0, 0, 1, 0, 2'd0);
      idle();
      chk_pend(2'd0, "R11 after vector");

      // R2: mode value 3 ignored, still vectored
      cyc(0, 0, 0, 0, 1, 2'd3);
      bus = 8'h77;
      cyc(0, 0, 1, 0, 0, 2'd0);
      cyc(0, 0, 0, 1, 0, 2'd0);   // R5: nothing pending, hold just clears
      cyc(1, 0, 0, 0, 0, 2'd0);
      expect_ack(2'd2, 16'h1276, 1'b0, 8'h00);   // R2 kind stays vectored
      cyc(0, 0, 0, 1, 0, 2'd0);
      idle();

      // R4: explicit disable from the released state
      cyc(0, 0, 1, 0, 0, 2'd0);
      cyc(0, 0, 0, 1, 0, 2'd0);
      cyc(0, 1, 0, 0, 0, 2'd0);
      cyc(1, 0, 0, 0, 0, 2'd0);
      idle();
      chk_pend(2'd1, "R4 after disable");
      cyc(0, 0, 0, 1, 0, 2'd0);
      idle();
      cyc(0, 0, 1, 0, 0, 2'd0);
      cyc(0, 0, 0, 1, 0, 2'd0);
      expect_ack(2'd2, 16'h1276, 1'b0, 8'h00);
      cyc(0, 0, 0, 1, 0, 2'd0);
      idle();

      // R7: both arrive while released, non-maskable goes first
      cyc(0, 0, 1, 0, 0, 2'd0);
      cyc(0, 0, 0, 1, 0, 2'd0);
      nmi = 1'b0;
      idle();
      nmi = 1'b1;
      cyc(1, 0, 0, 0, 0, 2'd0);
      idle();
      chk_pend(2'd3, "R7 both pending");
      bus = 8'hFF;
      expect_ack(2'd3, 16'h0066, 1'b0, 8'h00);
      cyc(0, 0, 0, 1, 0, 2'd0);
      idle();
      cyc(0, 0, 1, 0, 0, 2'd0);
      cyc(0, 0, 0, 1, 0, 2'd0);
      expect_ack(2'd2, 16'h12FE, 1'b0, 8'h00);
      cyc(0, 0, 0, 1, 0, 2'd0);
      repeat (4) idle();

      // R12: every expected acknowledge arrived, one cycle each
      report(exp_q.size() == 0, "R12 missing acknowledge", 32'(exp_q.size()), 0);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule